// File: doc/BRIEF.md
# ATM Receive Cell Filter with Per-Port Statistics

This block sits in the receive path of a multi-port cell interface. It examines every incoming 53-byte ATM cell and can discard Idle or Unassigned cells before they reach downstream logic. Each input beat carries one byte, a start-of-cell flag, a port number and an odd-parity bit. Cells arrive as 53 beats on consecutive cycles. Gaps of any length may sit between cells. Cells from different ports may follow each other directly.

The five header bytes pass through a five-stage delay line. The keep-or-drop decision is taken in the cycle the fifth header byte (the HEC) arrives. At that same edge, byte 0 of the cell reaches the output stage, so a discarded cell produces no output beats at all. Statistics are gathered in saturating counters of width `CNT_W`. There are three counters per port and one global parity counter. A host reads them through an `RD_W`-bit port, and the upper part is snapshotted so that the two reads of one counter belong together.

Top module: `atm_cell_filter`

## Requirements
- R1: When `cfg_drop_idle_i` is 1 at the HEC byte, an Idle cell is dropped: header bytes 0..3 read x0, 00, 00, 01, where the upper nibble of byte 0 is the GFC and is ignored. When the bit is 0 the cell is forwarded.
- R2: When `cfg_drop_unas_i` is 1 at the HEC byte, an Unassigned cell is dropped: header bytes read x0, 00, 00, 00, with the GFC ignored. This bit acts independently of the Idle bit.
- R3: The HEC is the CRC-8 (x^8+x^2+x+1, MSB first, initial value 0) of header bytes 0..3, XORed with 0x55 and compared with byte 4. A cell whose HEC is wrong is never treated as Idle or Unassigned, so it is always forwarded.
- R4: A forwarded byte appears on the output exactly 5 cycles after it was accepted, with its data, start flag and port unchanged. A dropped cell yields no `out_valid_o` beat.
- R5: The per-port class counter counts cells that have a good HEC and are Idle or Unassigned while `cfg_count_user_i`=0. While that bit is 1, it counts good-HEC cells that are neither.
- R6: The per-port HEC counter counts cells whose HEC is wrong. These cells are not counted in the class counter.
- R7: The per-port total counter counts every cell, dropped or forwarded.
- R8: A global counter counts accepted beats that fail odd parity, i.e. where `in_data_i` and `in_parity_i` together hold an even number of ones.
- R9: Every counter stops at all ones and does not wrap. All counters are 0 after reset.
- R10: Readout: `rd_sel_i` chooses the counter (0 class, 1 HEC, 2 total, 3 parity; the port is ignored for 3). A strobe with `rd_hi_i`=0 returns the low `RD_W` bits and snapshots the upper `CNT_W-RD_W` bits. A strobe with `rd_hi_i`=1 returns that snapshot zero-extended and then clears the snapshot.
- R11: `rd_data_o` is updated in the cycle after a strobe and holds its value otherwise. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_drop_idle_i | input | 1 | Discard Idle cells |
| cfg_drop_unas_i | input | 1 | Discard Unassigned cells |
| cfg_count_user_i | input | 1 | Class counter counts user cells instead of empty cells |
| in_valid_i | input | 1 | Input beat valid |
| in_soc_i | input | 1 | First byte of a cell |
| in_data_i | input | 8 | Cell byte |
| in_parity_i | input | 1 | Odd parity over `in_data_i` |
| in_port_i | input | PORT_W | Source port of the beat |
| out_valid_o | output | 1 | Output beat valid |
| out_soc_o | output | 1 | First byte of a forwarded cell |
| out_data_o | output | 8 | Forwarded byte |
| out_port_o | output | PORT_W | Port of the forwarded byte |
| rd_en_i | input | 1 | Counter read strobe |
| rd_sel_i | input | 2 | Counter select |
| rd_port_i | input | PORT_W | Port of the counter to read |
| rd_hi_i | input | 1 | 0 reads the low part, 1 reads the snapshot |
| rd_data_o | output | RD_W | Read data |

## Verification
Counter saturation is the hardest case to reach from the ports, because 24-bit counters would need millions of cells. The bench therefore builds the block with a 10-bit counter and an 8-bit read port. This keeps the split read meaningful. It then streams cells in which every byte has bad parity until the parity counter has gone well past its ceiling. The filtering corners are also driven in turn: Idle and Unassigned headers with a non-zero GFC, the same headers with a corrupted HEC while dropping is on, and back-to-back cells from different ports where one is dropped and its neighbours are not.

// File: rtl/atm_cf_pkg.sv
package atm_cf_pkg;

  localparam int unsigned CELL_BYTES = 53;
  localparam int unsigned HDR_BYTES  = 5;
  localparam logic [7:0]  HEC_COSET  = 8'h55;
  localparam logic [7:0]  HEC_POLY   = 8'h07;

  typedef enum logic [1:0] {
    SEL_CLASS  = 2'd0,
    SEL_HECERR = 2'd1,
    SEL_TOTAL  = 2'd2,
    SEL_PARITY = 2'd3
  } cnt_sel_e;

  // CRC-8 over 32 header bits, MSB first, then coset
  function automatic logic [7:0] hec_of(input logic [31:0] hdr);
    logic [7:0] crc;
    logic       fb;
    crc = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      fb  = crc[7] ^ hdr[i];
      crc = {crc[6:0], 1'b0} ^ (fb ? HEC_POLY : 8'h00);
    end
    return crc ^ HEC_COSET;
  endfunction

endpackage

// File: rtl/atm_cf_delay.sv
module atm_cf_delay #(
  parameter int unsigned DEPTH  = 5,
  parameter int unsigned PORT_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    soc_i,
  input  logic [7:0]              data_i,
  input  logic [PORT_W-1:0]       port_i,
  output logic [DEPTH-2:0][7:0]   hdr_o,
  output logic                    pre_valid_o,
  output logic                    pre_soc_o,
  output logic [PORT_W-1:0]       pre_port_o,
  output logic                    last_valid_o,
  output logic                    last_soc_o,
  output logic [7:0]              last_data_o,
  output logic [PORT_W-1:0]       last_port_o
);

  logic [DEPTH-1:0]             st_v;
  logic [DEPTH-1:0]             st_s;
  logic [DEPTH-1:0][7:0]        st_d;
  logic [DEPTH-1:0][PORT_W-1:0] st_p;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic              nv, ns;
    logic [7:0]        nd;
    logic [PORT_W-1:0] np;
    if (i == 0) begin : g_head
      assign nv = valid_i;
      assign ns = soc_i;
      assign nd = data_i;
      assign np = port_i;
    end else begin : g_body
      assign nv = st_v[i-1];
      assign ns = st_s[i-1];
      assign nd = st_d[i-1];
      assign np = st_p[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_v[i] <= 1'b0;
        st_s[i] <= 1'b0;
        st_d[i] <= '0;
        st_p[i] <= '0;
      end else begin
        st_v[i] <= nv;
        st_s[i] <= ns & nv;
        st_d[i] <= nd;
        st_p[i] <= np;
      end
    end
  end

  for (genvar k = 0; k < DEPTH - 1; k++) begin : g_tap
    assign hdr_o[k] = st_d[k];
  end

  assign pre_valid_o  = st_v[DEPTH-2];
  assign pre_soc_o    = st_s[DEPTH-2];
  assign pre_port_o   = st_p[DEPTH-2];
  assign last_valid_o = st_v[DEPTH-1];
  assign last_soc_o   = st_s[DEPTH-1];
  assign last_data_o  = st_d[DEPTH-1];
  assign last_port_o  = st_p[DEPTH-1];

endmodule

// File: rtl/atm_cf_classify.sv
module atm_cf_classify
  import atm_cf_pkg::*;
(
  input  logic [HDR_BYTES-1:0][7:0] hdr_i,   // index = byte number in cell
  output logic                      hec_ok_o,
  output logic                      idle_o,
  output logic                      unas_o
);

  logic zero_top;

  // GFC (upper nibble of byte 0) is don't-care
  assign zero_top = (hdr_i[0][3:0] == 4'h0) && (hdr_i[1] == 8'h00) && (hdr_i[2] == 8'h00);
  assign hec_ok_o = (hec_of({hdr_i[0], hdr_i[1], hdr_i[2], hdr_i[3]}) == hdr_i[4]);
  assign idle_o   = hec_ok_o && zero_top && (hdr_i[3] == 8'h01);
  assign unas_o   = hec_ok_o && zero_top && (hdr_i[3] == 8'h00);

endmodule

// File: rtl/atm_cf_sat_cnt.sv
module atm_cf_sat_cnt #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (inc_i && ~&cnt_o)     cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/atm_cell_filter.sv
module atm_cell_filter
  import atm_cf_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned RD_W      = 16,
  localparam int unsigned PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_drop_idle_i,
  input  logic              cfg_drop_unas_i,
  input  logic              cfg_count_user_i,
  input  logic              in_valid_i,
  input  logic              in_soc_i,
  input  logic [7:0]        in_data_i,
  input  logic              in_parity_i,
  input  logic [PORT_W-1:0] in_port_i,
  output logic              out_valid_o,
  output logic              out_soc_o,
  output logic [7:0]        out_data_o,
  output logic [PORT_W-1:0] out_port_o,
  input  logic              rd_en_i,
  input  logic [1:0]        rd_sel_i,
  input  logic [PORT_W-1:0] rd_port_i,
  input  logic              rd_hi_i,
  output logic [RD_W-1:0]   rd_data_o
);

  localparam int unsigned HI_W = CNT_W - RD_W;

  // ---------------- header delay ----------------
  logic [HDR_BYTES-2:0][7:0] tap;
  logic                      pre_valid, pre_soc;
  logic [PORT_W-1:0]         pre_port;
  logic                      last_valid, last_soc;
  logic [7:0]                last_data;
  logic [PORT_W-1:0]         last_port;

  atm_cf_delay #(.DEPTH(HDR_BYTES), .PORT_W(PORT_W)) u_delay (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (in_valid_i),
    .soc_i        (in_soc_i),
    .data_i       (in_data_i),
    .port_i       (in_port_i),
    .hdr_o        (tap),
    .pre_valid_o  (pre_valid),
    .pre_soc_o    (pre_soc),
    .pre_port_o   (pre_port),
    .last_valid_o (last_valid),
    .last_soc_o   (last_soc),
    .last_data_o  (last_data),
    .last_port_o  (last_port)
  );

  logic [HDR_BYTES-1:0][7:0] hdr;
  for (genvar j = 0; j < HDR_BYTES - 1; j++) begin : g_hdr
    assign hdr[j] = tap[HDR_BYTES-2-j];
  end
  assign hdr[HDR_BYTES-1] = in_data_i;

  // ---------------- classification / decision ----------------
  logic hec_ok, is_idle, is_unas;

  atm_cf_classify u_class (
    .hdr_i    (hdr),
    .hec_ok_o (hec_ok),
    .idle_o   (is_idle),
    .unas_o   (is_unas)
  );

  logic decide, drop_d, drop_q;
  assign decide = in_valid_i && pre_valid && pre_soc;
  assign drop_d = (is_idle && cfg_drop_idle_i) || (is_unas && cfg_drop_unas_i);

  // takes effect on the edge byte 0 enters the output stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     drop_q <= 1'b0;
    else if (decide) drop_q <= drop_d;
  end

  assign out_valid_o = last_valid && !drop_q;
  assign out_soc_o   = last_soc && !drop_q;
  assign out_data_o  = last_data;
  assign out_port_o  = last_port;

  // ---------------- statistics ----------------
  logic empty_cell, class_hit;
  assign empty_cell = is_idle || is_unas;
  assign class_hit  = hec_ok && (cfg_count_user_i ? !empty_cell : empty_cell);

  logic [NUM_PORTS-1:0][CNT_W-1:0] cls_cnt, hec_cnt, tot_cnt;
  logic [CNT_W-1:0]                par_cnt;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit = decide && (pre_port == PORT_W'(p));

    atm_cf_sat_cnt #(.W(CNT_W)) u_cls (
      .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (hit && class_hit), .cnt_o (cls_cnt[p]));
    atm_cf_sat_cnt #(.W(CNT_W)) u_hec (
      .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (hit && !hec_ok), .cnt_o (hec_cnt[p]));
    atm_cf_sat_cnt #(.W(CNT_W)) u_tot (
      .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (hit), .cnt_o (tot_cnt[p]));
  end

  logic par_err;
  assign par_err = in_valid_i && !(^{in_data_i, in_parity_i});

  atm_cf_sat_cnt #(.W(CNT_W)) u_par (
    .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (par_err), .cnt_o (par_cnt));

  // ---------------- readout ----------------
  cnt_sel_e         sel;
  logic [CNT_W-1:0] sel_val;
  logic [HI_W-1:0]  hi_snap;
  logic [RD_W-1:0]  rd_q;

  assign sel = cnt_sel_e'(rd_sel_i);

  always_comb begin
    unique case (sel)
      SEL_CLASS:  sel_val = cls_cnt[rd_port_i];
      SEL_HECERR: sel_val = hec_cnt[rd_port_i];
      SEL_TOTAL:  sel_val = tot_cnt[rd_port_i];
      default:    sel_val = par_cnt;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= '0;
      hi_snap <= '0;
    end else if (rd_en_i) begin
      if (rd_hi_i) begin
        rd_q    <= {{(RD_W-HI_W){1'b0}}, hi_snap};
        hi_snap <= '0;
      end else begin
        rd_q    <= sel_val[RD_W-1:0];
        hi_snap <= sel_val[CNT_W-1:RD_W];
      end
    end
  end

  assign rd_data_o = rd_q;

endmodule

// File: rtl/atm_cf_checker.sv
module atm_cf_checker #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned RD_W      = 16,
  localparam int unsigned HI_W     = CNT_W - RD_W
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            in_valid_i,
  input logic [7:0]                      in_data_i,
  input logic                            out_valid_o,
  input logic                            out_soc_o,
  input logic [7:0]                      out_data_o,
  input logic                            rd_en_i,
  input logic                            rd_hi_i,
  input logic [RD_W-1:0]                 rd_data_o,
  input logic [NUM_PORTS-1:0][CNT_W-1:0] tot_cnt_i
);

  a_r4_fwd_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($past(in_valid_i, 5) && out_data_o == $past(in_data_i, 5)));

  a_r4_cell_whole: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_soc_o) |=> out_valid_o);

  a_r10_hi_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_hi_i) |=> (rd_data_o[RD_W-1:HI_W] == '0));

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mono
    // R7/R9: total moves up by at most one and never wraps
    a_r9_tot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tot_cnt_i[p] == $past(tot_cnt_i[p])) || (tot_cnt_i[p] == $past(tot_cnt_i[p]) + 1'b1));
  end

endmodule

bind atm_cell_filter atm_cf_checker #(
  .NUM_PORTS (NUM_PORTS),
  .CNT_W     (CNT_W),
  .RD_W      (RD_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_data_i   (in_data_i),
  .out_valid_o (out_valid_o),
  .out_soc_o   (out_soc_o),
  .out_data_o  (out_data_o),
  .rd_en_i     (rd_en_i),
  .rd_hi_i     (rd_hi_i),
  .rd_data_o   (rd_data_o),
  .tot_cnt_i   (tot_cnt)
);

// File: tb/atm_cell_filter_test.sv
module atm_cell_filter_test;

  localparam int NP  = 4;
  localparam int CW  = 10;
  localparam int RW  = 8;
  localparam int PW  = 2;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          drop_idle = 0, drop_unas = 0, count_user = 0;
  logic          in_valid = 0, in_soc = 0, in_par = 0;
  logic [7:0]    in_data = 0;
  logic [PW-1:0] in_port = 0;
  logic          out_valid, out_soc;
  logic [7:0]    out_data;
  logic [PW-1:0] out_port;
  logic          rd_en = 0, rd_hi = 0;
  logic [1:0]    rd_sel = 0;
  logic [PW-1:0] rd_port = 0;
  logic [RW-1:0] rd_data;
  logic          drv_keep = 0;

  atm_cell_filter #(.NUM_PORTS(NP), .CNT_W(CW), .RD_W(RW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_drop_idle_i(drop_idle), .cfg_drop_unas_i(drop_unas), .cfg_count_user_i(count_user),
    .in_valid_i(in_valid), .in_soc_i(in_soc), .in_data_i(in_data), .in_parity_i(in_par),
    .in_port_i(in_port),
    .out_valid_o(out_valid), .out_soc_o(out_soc), .out_data_o(out_data), .out_port_o(out_port),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel), .rd_port_i(rd_port), .rd_hi_i(rd_hi),
    .rd_data_o(rd_data));

  int total = 0, bad = 0;
  bit done = 0;

  int m_cls[NP], m_hec[NP], m_tot[NP];
  int m_par = 0;
  int seq = 0;

  typedef struct packed {
    logic          v;
    logic          s;
    logic [7:0]    d;
    logic [PW-1:0] p;
  } beat_t;
  beat_t expq[$];

  function automatic int sat(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  // byte-wise CRC-8, poly 0x07, then coset 0x55
  function automatic logic [7:0] ref_hec(input logic [7:0] a, b, c, d);
    logic [7:0] bytes[4];
    logic [7:0] r;
    bytes[0] = a; bytes[1] = b; bytes[2] = c; bytes[3] = d;
    r = 8'h00;
    foreach (bytes[i]) begin
      r = r ^ bytes[i];
      for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    end
    return r ^ 8'h55;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference stream model
  always @(posedge clk) begin
    if (!rst_n) expq.delete();
    else begin
      beat_t e;
      e.v = in_valid && drv_keep;
      e.s = in_soc && e.v;
      e.d = in_data;
      e.p = in_port;
      expq.push_back(e);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      beat_t e;
      e = '0;
      if (expq.size() == 5) e = expq.pop_front();
      if (e.v || out_valid) begin
        check(out_valid == e.v, "R4", "out_valid", out_valid, e.v);
        if (e.v && out_valid) begin
          check(out_soc == e.s, "R4", "out_soc", out_soc, e.s);
          check(out_data == e.d, "R4", "out_data", out_data, e.d);
          check(out_port == e.p, "R4", "out_port", out_port, e.p);
        end
      end
    end
  end

  // kind: 0 user, 1 idle, 2 unassigned
  task automatic send_cell(input int port, input int kind, input bit gfc, input bit bad_hec, input bit bad_par);
    logic [7:0] b[53];
    bit keep, empty;
    b[0] = {gfc ? 4'hA : 4'h0, 4'h0};
    b[1] = 8'h00;
    b[2] = (kind == 0) ? 8'h01 : 8'h00;
    b[3] = (kind == 0) ? 8'h20 : (kind == 1 ? 8'h01 : 8'h00);
    b[4] = ref_hec(b[0], b[1], b[2], b[3]) ^ (bad_hec ? 8'h04 : 8'h00);
    for (int i = 5; i < 53; i++) b[i] = 8'((i * 7 + seq * 13) & 8'hFF);
    seq++;
    empty = !bad_hec && (kind != 0);
    keep = !(!bad_hec && ((kind == 1 && drop_idle) || (kind == 2 && drop_unas)));
    m_tot[port]++;
    if (bad_hec) m_hec[port]++;
    else if (count_user ? (kind == 0) : empty) m_cls[port]++;
    if (bad_par) m_par += 53;
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      in_valid = 1; in_soc = (i == 0); in_data = b[i];
      in_par = bad_par ? ^b[i] : ~^b[i];
      in_port = PW'(port); drv_keep = keep;
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_soc = 0; drv_keep = 0;
    end
  endtask

  task automatic rd(input int sel, input int port, input bit hi, output int val);
    @(negedge clk);
    rd_en = 1; rd_sel = 2'(sel); rd_port = PW'(port); rd_hi = hi;
    @(negedge clk);
    rd_en = 0;
    val = int'(rd_data);
  endtask

  task automatic rd_check(input int sel, input int port, input int exp, input string req);
    int v;
    rd(sel, port, 0, v);
    check(v == (exp & ((1 << RW) - 1)), req, $sformatf("low sel%0d p%0d", sel, port), v, exp & ((1 << RW) - 1));
    rd(sel, port, 1, v);
    check(v == (exp >> RW), req, $sformatf("high sel%0d p%0d", sel, port), v, exp >> RW);
  endtask

  task automatic check_all_counters();
    idle_cycles(8);
    for (int p = 0; p < NP; p++) begin
      rd_check(0, p, sat(m_cls[p]), "R5");
      rd_check(1, p, sat(m_hec[p]), "R6");
      rd_check(2, p, sat(m_tot[p]), "R7");
    end
    rd_check(3, 0, sat(m_par), "R8");
  endtask

  initial begin
    int v;
    foreach (m_cls[i]) begin m_cls[i] = 0; m_hec[i] = 0; m_tot[i] = 0; end
    repeat (3) @(negedge clk);
    check(rd_data == 0, "R11", "rd_data in reset", rd_data, 0);
    check(out_valid == 0, "R4", "out_valid in reset", out_valid, 0);
    rst_n = 1;
    idle_cycles(4);
    check(rd_data == 0, "R11", "rd_data after reset", rd_data, 0);
    rd_check(2, 1, 0, "R9");

    // no filtering: everything forwarded
    send_cell(0, 0, 0, 0, 0);
    send_cell(1, 1, 0, 0, 0);
    send_cell(2, 2, 1, 0, 0);
    send_cell(3, 1, 0, 1, 0);
    send_cell(0, 0, 0, 0, 1);   // R8 parity errors
    idle_cycles(3);

    // R1: idle dropping, GFC ignored, bad HEC kept (R3)
    drop_idle = 1;
    send_cell(1, 1, 0, 0, 0);
    send_cell(1, 2, 0, 0, 0);
    send_cell(1, 1, 1, 0, 0);
    send_cell(2, 1, 0, 1, 0);
    send_cell(3, 0, 0, 0, 0);
    idle_cycles(2);

    // R2: unassigned dropping alone
    drop_idle = 0; drop_unas = 1;
    send_cell(2, 2, 0, 0, 0);
    send_cell(2, 1, 0, 0, 0);
    send_cell(2, 2, 1, 0, 0);
    send_cell(0, 2, 0, 1, 0);
    idle_cycles(2);

    // both on, back-to-back ports
    drop_idle = 1;
    send_cell(0, 0, 0, 0, 0);
    send_cell(1, 1, 0, 0, 0);
    send_cell(2, 0, 1, 0, 0);
    send_cell(3, 2, 0, 0, 0);
    send_cell(0, 0, 0, 0, 0);
    check_all_counters();

    // R5: user-cell counting mode
    count_user = 1;
    send_cell(3, 0, 0, 0, 0);
    send_cell(3, 0, 1, 0, 0);
    send_cell(3, 1, 0, 0, 0);
    send_cell(3, 0, 0, 1, 0);
    check_all_counters();

    // R10: snapshot cleared after a high read
    rd(2, 3, 0, v);
    rd(2, 3, 1, v);
    rd(2, 3, 1, v);
    check(v == 0, "R10", "second high read", v, 0);
    rd(1, 0, 1, v);
    check(v == 0, "R10", "high read without low", v, 0);

    // R11: value held with no strobe
    rd(2, 0, 0, v);
    idle_cycles(5);
    check(int'(rd_data) == v, "R11", "rd_data hold", rd_data, v);

    // R9: saturate parity counter
    drop_idle = 0; drop_unas = 0; count_user = 0;
    for (int n = 0; n < 22; n++) send_cell(n % NP, 0, 0, 0, 1);
    check_all_counters();
    check(m_par > MAXC, "R9", "parity model past limit", m_par, MAXC);

    idle_cycles(4);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule